// File: doc/BRIEF.md
# Protection Controller Register Interface

This block is the software-visible configuration side of a memory access filter. The filter splits a protected memory range into fixed-size blocks. A lookup table holds one bit per block and says which security domain may use that block. Software reaches the table through one data window. An index register selects which 32-bit table word the window addresses. The index can advance by itself after each full-word access, so a loop of word accesses can stream through the whole table.

The same register file holds the error response policy for blocked accesses and the interrupt state for them. When the filter reports a blocked access, the block records its address and attributes in two information registers. It only records an access when no earlier event is still pending. A sticky lockdown bit freezes the control word, the table and the interrupt enable until the next reset. Masters without the secure attribute can reach only a constant identification area; every other offset reads zero for them and ignores their writes.

Accesses use a 12-bit byte offset and a size code: 0 is a byte, 1 is a halfword, 2 is a word. Write data and read data are right-aligned to the addressed bytes. Read data is combinational in the cycle of the request, and register updates take effect at the next rising clock edge.

Top module: `prot_ctrl_regs`

## Requirements
- R1: After reset the control word is 0x100, the index is 0, the pending status is 0, the interrupt enable is 1, both information words are 0, every table word is 0 and `irq_out` is low.
- R2: The control word at offset 0x00 keeps only bit 4 (error response, driven on `resp_err_en`), bit 8 (auto-advance) and bit 31 (lockdown). All other bits read as zero.
- R3: Offset 0x10 reads the number of table words (`BLK_WORDS`). Offset 0x14 reads `BLK_BYTES_LOG2` minus 5. Writes to either offset change nothing.
- R4: A write to the index at 0x18 stores the written value modulo `BLK_WORDS`, and the index reads back at 0x18.
- R5: The window at 0x1C reads and writes the table word selected by the index. Table word i appears on `lut_bits[32*i+31:32*i]`.
- R6: With bit 8 of control set, a word-sized read or write of 0x1C advances the index by one, wrapping from `BLK_WORDS`-1 to 0. Byte and halfword accesses do not advance it, and no access advances it while bit 8 is clear.
- R7: Once bit 31 of control is set, writes to control, to the window and to the enable at 0x28 are ignored, and the bit stays set until reset. The index, set and clear registers still work, and window reads still advance the index.
- R8: A request with `acc_secure` low below offset 0xFD0 reads zero and changes no state. Such a request can still read the identification words.
- R9: A write with bit 0 set to 0x34 raises the pending status, and a write with bit 0 set to 0x24 clears it. Both offsets read zero. Offset 0x20 reads the status and 0x28 reads the enable (bit 0). `irq_out` is high exactly when both the status and the enable are 1.
- R10: A `flt_valid` pulse while the status is clear sets the status. It stores `flt_addr` at 0x2C, and at 0x30 it stores `flt_master` in bits 15:0, `flt_nonsec` in bit 16 and `flt_cfg_ns` in bit 17. Pulses while the status is set leave both words unchanged.
- R11: Sub-word writes to control, index and window replace only the addressed bytes of the current value. Sub-word writes to the other registers treat the bytes that were not written as zero. Sub-word reads return the addressed bytes shifted down to bit 0.
- R12: The twelve words at 0xFD0 to 0xFFC (step 4) read the bytes 04, 00, 00, 00, 60, B8, 1B, 00, 0D, F0, 05, B1 in address order, zero-extended. Writes to them are ignored.
- R13: Offsets that hold no register read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Security attribute of the access |
| acc_addr | input | 12 | Byte offset |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_wdata | input | 32 | Right-aligned write data |
| acc_rdata | output | 32 | Right-aligned read data, same cycle |
| flt_valid | input | 1 | Filter reports a blocked access |
| flt_addr | input | 32 | Address of the blocked access |
| flt_master | input | 16 | Requester identity |
| flt_nonsec | input | 1 | Blocked access was non-secure |
| flt_cfg_ns | input | 1 | Table bit of the addressed block |
| lut_bits | output | BLK_WORDS*32 | Whole lookup table for the filter |
| resp_err_en | output | 1 | Blocked accesses answer with an error |
| irq_out | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the interactions of the sticky lockdown. It must block control, window and enable writes, yet it must keep index writes working and must keep auto-advance on window reads. The only way out is a reset, so the bench runs lockdown as the last phase before a final reset and checks every register after it. The index wrap is checked with a table size that is not a power of two, using streams of word writes that cross the wrap point. Between these streams, byte and halfword accesses to the window check that the index stays put.

// File: rtl/mpcr_pkg.sv
package mpcr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_BMAX   = 12'h010;
  localparam logic [11:0] OFS_BCFG   = 12'h014;
  localparam logic [11:0] OFS_BIDX   = 12'h018;
  localparam logic [11:0] OFS_LUTD   = 12'h01C;
  localparam logic [11:0] OFS_ISTAT  = 12'h020;
  localparam logic [11:0] OFS_ICLR   = 12'h024;
  localparam logic [11:0] OFS_IEN    = 12'h028;
  localparam logic [11:0] OFS_INFOA  = 12'h02C;
  localparam logic [11:0] OFS_INFOB  = 12'h030;
  localparam logic [11:0] OFS_ISET   = 12'h034;
  localparam logic [11:0] OFS_IDBASE = 12'hFD0;

  localparam int CTRL_SRESP = 4;
  localparam int CTRL_AINC  = 8;
  localparam int CTRL_LOCK  = 31;
  localparam logic [31:0] CTRL_KEEP  = (32'h1 << CTRL_SRESP) | (32'h1 << CTRL_AINC) |
                                       (32'h1 << CTRL_LOCK);
  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;

  typedef struct packed {
    logic ctrl;
    logic bmax;
    logic bcfg;
    logic bidx;
    logic lutd;
    logic istat;
    logic iclr;
    logic ien;
    logic infoa;
    logic infob;
    logic iset;
    logic idreg;
  } reg_sel_t;

  function automatic logic [31:0] width_mask(acc_size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] eff_lane(acc_size_e sz, logic [1:0] a);
    return (sz == SZ_BYTE || sz == SZ_HALF) ? a : 2'b00;
  endfunction

  // Replace the addressed bytes of old with the right-aligned data.
  function automatic logic [31:0] merge_bytes(logic [31:0] old, logic [31:0] data,
                                              acc_size_e sz, logic [1:0] lane);
    logic [31:0] m;
    m = width_mask(sz) << {lane, 3'b000};
    return (old & ~m) | ((data << {lane, 3'b000}) & m);
  endfunction

  function automatic logic [31:0] pick_bytes(logic [31:0] word, acc_size_e sz,
                                             logic [1:0] lane);
    return (word >> {lane, 3'b000}) & width_mask(sz);
  endfunction

  function automatic logic [7:0] id_byte(logic [3:0] k);
    case (k)
      4'd0:    return 8'h04;
      4'd4:    return 8'h60;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mpcr_decode.sv
module mpcr_decode
  import mpcr_pkg::*;
(
  input  logic [11:0] addr,
  output reg_sel_t    sel,
  output logic        in_id,
  output logic [3:0]  id_k
);
  logic [11:0] ofs;
  logic [11:0] id_diff;

  assign ofs     = {addr[11:2], 2'b00};
  assign in_id   = (ofs >= OFS_IDBASE);
  assign id_diff = ofs - OFS_IDBASE;
  assign id_k    = id_diff[5:2];

  always_comb begin
    sel       = '0;
    sel.ctrl  = (ofs == OFS_CTRL);
    sel.bmax  = (ofs == OFS_BMAX);
    sel.bcfg  = (ofs == OFS_BCFG);
    sel.bidx  = (ofs == OFS_BIDX);
    sel.lutd  = (ofs == OFS_LUTD);
    sel.istat = (ofs == OFS_ISTAT);
    sel.iclr  = (ofs == OFS_ICLR);
    sel.ien   = (ofs == OFS_IEN);
    sel.infoa = (ofs == OFS_INFOA);
    sel.infob = (ofs == OFS_INFOB);
    sel.iset  = (ofs == OFS_ISET);
    sel.idreg = in_id;
  end
endmodule

// File: rtl/mpcr_lut.sv
module mpcr_lut
  import mpcr_pkg::*;
#(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_we,
  input  logic            lut_we,
  input  logic            adv,
  input  logic [31:0]     wdata,
  input  acc_size_e       sz,
  input  logic [1:0]      lane,
  output logic [IW-1:0]   idx_q,
  output logic [31:0]     cur_word,
  output logic [N*32-1:0] lut_flat
);
  logic [31:0]   idx_merged;
  logic [31:0]   idx_folded;
  logic [31:0]   lut_merged;
  logic [IW-1:0] idx_next_inc;

  assign cur_word     = lut_flat[32*int'(idx_q) +: 32];
  assign idx_merged   = merge_bytes(32'(idx_q), wdata, sz, lane);
  assign idx_folded   = idx_merged % 32'(N);
  assign lut_merged   = merge_bytes(cur_word, wdata, sz, lane);
  assign idx_next_inc = (idx_q == IW'(N - 1)) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= IW'(idx_folded);
    else if (adv)    idx_q <= idx_next_inc;
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              word_q <= '0;
      else if (lut_we && idx_q == IW'(gi))     word_q <= lut_merged;
    end
    assign lut_flat[32*gi +: 32] = word_q;
  end

  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < N);

  a_r6_adv_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !idx_we && (int'(idx_q) < N - 1) |=> int'(idx_q) == int'($past(idx_q)) + 1);
endmodule

// File: rtl/mpcr_irq.sv
module mpcr_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_hit,
  input  logic        clr_hit,
  input  logic        en_we,
  input  logic        en_val,
  input  logic        flt_valid,
  input  logic [31:0] flt_addr,
  input  logic [15:0] flt_master,
  input  logic        flt_nonsec,
  input  logic        flt_cfg_ns,
  output logic        stat_q,
  output logic        en_q,
  output logic [31:0] info_a_q,
  output logic [31:0] info_b_q,
  output logic        irq
);
  logic capture;

  assign capture = flt_valid && (!stat_q || clr_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= 1'b0;
      en_q     <= 1'b1;
      info_a_q <= '0;
      info_b_q <= '0;
    end else begin
      stat_q <= set_hit || capture || (stat_q && !clr_hit);
      if (en_we) en_q <= en_val;
      if (capture) begin
        info_a_q <= flt_addr;
        info_b_q <= {14'b0, flt_cfg_ns, flt_nonsec, flt_master};
      end
    end
  end

  assign irq = stat_q && en_q;

  a_r10_info_held: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !clr_hit |=> $stable(info_a_q) && $stable(info_b_q));

  a_r9_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> stat_q);

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !set_hit && !flt_valid |=> !stat_q);
endmodule

// File: rtl/prot_ctrl_regs.sv
module prot_ctrl_regs
  import mpcr_pkg::*;
#(
  parameter int BLK_WORDS      = 3,
  parameter int BLK_BYTES_LOG2 = 12,
  localparam int IW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_req,
  input  logic                   acc_write,
  input  logic                   acc_secure,
  input  logic [11:0]            acc_addr,
  input  logic [1:0]             acc_size,
  input  logic [31:0]            acc_wdata,
  output logic [31:0]            acc_rdata,
  input  logic                   flt_valid,
  input  logic [31:0]            flt_addr,
  input  logic [15:0]            flt_master,
  input  logic                   flt_nonsec,
  input  logic                   flt_cfg_ns,
  output logic [BLK_WORDS*32-1:0] lut_bits,
  output logic                   resp_err_en,
  output logic                   irq_out
);
  localparam logic [31:0] BMAX_VAL = 32'(BLK_WORDS);
  localparam logic [31:0] BCFG_VAL = 32'(BLK_BYTES_LOG2 - 5);

  acc_size_e   sz;
  logic [1:0]  lane;
  reg_sel_t    sel;
  logic        in_id;
  logic [3:0]  id_k;
  logic        acc_ok, rd_en, wr_en, locked;
  logic [31:0] wval_zero;
  logic [31:0] ctrl_q;
  logic [IW-1:0] idx_q;
  logic [31:0] cur_word;
  logic        stat_q, en_q;
  logic [31:0] info_a_q, info_b_q;
  logic [31:0] rd_word;

  // named internal events
  logic ctrl_we, lut_we, idx_we, en_we, set_hit, clr_hit, lut_adv;

  assign sz   = acc_size_e'(acc_size);
  assign lane = eff_lane(sz, acc_addr[1:0]);

  mpcr_decode u_dec (
    .addr (acc_addr),
    .sel  (sel),
    .in_id(in_id),
    .id_k (id_k)
  );

  assign acc_ok    = acc_req && (acc_secure || in_id);
  assign rd_en     = acc_ok && !acc_write;
  assign wr_en     = acc_ok && acc_write;
  assign locked    = ctrl_q[CTRL_LOCK];
  assign wval_zero = merge_bytes(32'h0, acc_wdata, sz, lane);

  assign ctrl_we = wr_en && sel.ctrl && !locked;
  assign lut_we  = wr_en && sel.lutd && !locked;
  assign en_we   = wr_en && sel.ien  && !locked;
  assign idx_we  = wr_en && sel.bidx;
  assign set_hit = wr_en && sel.iset && wval_zero[0];
  assign clr_hit = wr_en && sel.iclr && wval_zero[0];
  assign lut_adv = acc_ok && sel.lutd && (sz == SZ_WORD) && ctrl_q[CTRL_AINC] &&
                   (!acc_write || !locked);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_we) ctrl_q <= merge_bytes(ctrl_q, acc_wdata, sz, lane) & CTRL_KEEP;
  end

  mpcr_lut #(.N(BLK_WORDS)) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_we  (idx_we),
    .lut_we  (lut_we),
    .adv     (lut_adv),
    .wdata   (acc_wdata),
    .sz      (sz),
    .lane    (lane),
    .idx_q   (idx_q),
    .cur_word(cur_word),
    .lut_flat(lut_bits)
  );

  mpcr_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_hit   (set_hit),
    .clr_hit   (clr_hit),
    .en_we     (en_we),
    .en_val    (wval_zero[0]),
    .flt_valid (flt_valid),
    .flt_addr  (flt_addr),
    .flt_master(flt_master),
    .flt_nonsec(flt_nonsec),
    .flt_cfg_ns(flt_cfg_ns),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .info_a_q  (info_a_q),
    .info_b_q  (info_b_q),
    .irq       (irq_out)
  );

  always_comb begin
    rd_word = 32'h0;
    if (sel.ctrl)       rd_word = ctrl_q;
    else if (sel.bmax)  rd_word = BMAX_VAL;
    else if (sel.bcfg)  rd_word = BCFG_VAL;
    else if (sel.bidx)  rd_word = 32'(idx_q);
    else if (sel.lutd)  rd_word = cur_word;
    else if (sel.istat) rd_word = {31'b0, stat_q};
    else if (sel.ien)   rd_word = {31'b0, en_q};
    else if (sel.infoa) rd_word = info_a_q;
    else if (sel.infob) rd_word = info_b_q;
    else if (sel.idreg) rd_word = {24'b0, id_byte(id_k)};
  end

  assign acc_rdata   = rd_en ? pick_bytes(rd_word, sz, lane) : 32'h0;
  assign resp_err_en = ctrl_q[CTRL_SRESP];

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r7_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl_q));

  a_r7_lut_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(lut_bits) && ($stable(en_q) || !$past(locked)));

  a_r8_ns_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_write && !acc_secure && !in_id |=>
      $stable(ctrl_q) && $stable(idx_q) && $stable(lut_bits) && $stable(en_q));

  a_r8_ns_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_write && !acc_secure && !in_id |-> acc_rdata == 32'h0);

  a_r6_subword_keeps_idx: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && sel.lutd && sz != SZ_WORD |=> $stable(idx_q));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q & ~CTRL_KEEP) == 32'h0);
endmodule

// File: tb/prot_ctrl_regs_bench.sv
`timescale 1ns/1ps
module prot_ctrl_regs_bench;
  localparam int NW = 3;
  localparam int LG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 1'b0, acc_write = 1'b0, acc_secure = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic flt_valid = 1'b0;
  logic [31:0] flt_addr = '0;
  logic [15:0] flt_master = '0;
  logic flt_nonsec = 1'b0, flt_cfg_ns = 1'b0;
  logic [NW*32-1:0] lut_bits;
  logic resp_err_en, irq_out;

  always #4 clk = ~clk;

  prot_ctrl_regs #(.BLK_WORDS(NW), .BLK_BYTES_LOG2(LG)) u_prot_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write),
    .acc_secure(acc_secure), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .flt_valid(flt_valid),
    .flt_addr(flt_addr), .flt_master(flt_master), .flt_nonsec(flt_nonsec),
    .flt_cfg_ns(flt_cfg_ns), .lut_bits(lut_bits), .resp_err_en(resp_err_en),
    .irq_out(irq_out)
  );

  int n_cmp = 0, n_bad = 0;

  // bench-side model
  logic [31:0] m_ctrl, m_lut [NW], m_info_a, m_info_b;
  int m_idx;
  logic m_stat, m_en;

  task automatic model_reset();
    m_ctrl = 32'h100; m_idx = 0; m_stat = 0; m_en = 1;
    m_info_a = 0; m_info_b = 0;
    for (int i = 0; i < NW; i++) m_lut[i] = 0;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] id_val(int k);
    case (k)
      0: return 8'h04; 4: return 8'h60; 5: return 8'hB8; 6: return 8'h1B;
      8: return 8'h0D; 9: return 8'hF0; 10: return 8'h05; 11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int nbytes(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(int a, int sz, bit sec);
    int ofs = a & 32'hFFC;
    int ln = (sz >= 2) ? 0 : (a & 3);
    logic [31:0] w;
    logic [31:0] r;
    if (!sec && ofs < 'hFD0) return 0;
    case (ofs)
      'h000: w = m_ctrl;
      'h010: w = NW;
      'h014: w = LG - 5;
      'h018: w = m_idx;
      'h01C: w = m_lut[m_idx];
      'h020: w = {31'b0, m_stat};
      'h028: w = {31'b0, m_en};
      'h02C: w = m_info_a;
      'h030: w = m_info_b;
      default: w = (ofs >= 'hFD0) ? {24'b0, id_val((ofs - 'hFD0) / 4)} : 0;
    endcase
    r = 0;
    for (int b = 0; b < nbytes(sz); b++) r[b*8 +: 8] = w[(ln + b)*8 +: 8];
    return r;
  endfunction

  function automatic string sweep_tag(int a);
    if (a >= 'hFD0) return "R12";
    if (a == 0 || (a >= 'h10 && a <= 'h34)) return "R1";
    return "R13";
  endfunction

  task automatic drive(bit wr, int a, int sz, bit sec, logic [31:0] d);
    @(negedge clk);
    acc_req = 1; acc_write = wr; acc_addr = 12'(a); acc_size = 2'(sz);
    acc_secure = sec; acc_wdata = d;
    #2;
  endtask

  task automatic rd(int a, int sz, bit sec, string tag);
    logic [31:0] e;
    int ofs = a & 32'hFFC;
    e = exp_read(a, sz, sec);
    drive(0, a, sz, sec, 0);
    chk(tag, acc_rdata, e);
    @(posedge clk); #1; acc_req = 0;
    if ((sec || ofs >= 'hFD0) && ofs == 'h1C && sz == 2 && m_ctrl[8]) m_idx = (m_idx + 1) % NW;
  endtask

  task automatic wr(int a, int sz, bit sec, logic [31:0] d);
    int ofs = a & 32'hFFC;
    int ln = (sz >= 2) ? 0 : (a & 3);
    logic [31:0] old, v;
    drive(1, a, sz, sec, d);
    @(posedge clk); #1; acc_req = 0;
    if (!sec && ofs < 'hFD0) return;
    old = (ofs == 0) ? m_ctrl : (ofs == 'h18) ? 32'(m_idx) : (ofs == 'h1C) ? m_lut[m_idx] : 0;
    v = old;
    for (int b = 0; b < nbytes(sz); b++) v[(ln + b)*8 +: 8] = d[b*8 +: 8];
    if (m_ctrl[31] && (ofs == 0 || ofs == 'h1C || ofs == 'h28)) return;
    case (ofs)
      'h000: m_ctrl = v & 32'h8000_0110;
      'h018: m_idx = int'(v % NW);
      'h01C: begin m_lut[m_idx] = v; if (sz == 2 && m_ctrl[8]) m_idx = (m_idx + 1) % NW; end
      'h024: if (v[0]) m_stat = 0;
      'h028: m_en = v[0];
      'h034: if (v[0]) m_stat = 1;
      default: ;
    endcase
  endtask

  task automatic fault(logic [31:0] a, logic [15:0] m, bit ns, bit cfg);
    @(negedge clk);
    flt_valid = 1; flt_addr = a; flt_master = m; flt_nonsec = ns; flt_cfg_ns = cfg;
    @(posedge clk); #1; flt_valid = 0;
    if (!m_stat) begin
      m_stat = 1; m_info_a = a; m_info_b = {14'b0, cfg, ns, m};
    end
  endtask

  task automatic do_reset();
    acc_req = 0; flt_valid = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
  endtask

  task automatic check_outs(string tag);
    chk(tag, {31'b0, irq_out}, {31'b0, m_stat & m_en});
    chk(tag, {31'b0, resp_err_en}, {31'b0, m_ctrl[4]});
    for (int i = 0; i < NW; i++) chk(tag, lut_bits[i*32 +: 32], m_lut[i]);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 R3 R12 R13: secure sweep of every word offset
    check_outs("R1");
    for (int a = 0; a < 4096; a += 4) rd(a, 2, 1, sweep_tag(a));
    // R8: non-secure sweep, reads and writes
    for (int a = 0; a < 4096; a += 4) rd(a, 2, 0, "R8");
    for (int a = 0; a < 'h40; a += 4) wr(a, 2, 0, 32'hFFFF_FFFF);
    for (int a = 0; a < 'h40; a += 4) rd(a, 2, 1, "R8");
    check_outs("R8");
    // R3 R12 R13: writes to read-only and unmapped offsets
    wr('h10, 2, 1, 32'h55); wr('h14, 2, 1, 32'h55); wr('hFD0, 2, 1, 32'hFF);
    wr('h40, 2, 1, 32'hFFFF_FFFF); wr('h800, 2, 1, 32'h1234);
    rd('h10, 2, 1, "R3"); rd('h14, 2, 1, "R3"); rd('hFD0, 2, 1, "R12");
    rd('h40, 2, 1, "R13"); rd('h800, 2, 1, "R13");
    // R2: control masking
    wr('h00, 2, 1, 32'h7FFF_FFFF); rd('h00, 2, 1, "R2"); check_outs("R2");
    wr('h00, 2, 1, 32'h0); rd('h00, 2, 1, "R2"); check_outs("R2");
    // R4: index modulo
    for (int v = 0; v < 8; v++) begin wr('h18, 2, 1, v); rd('h18, 2, 1, "R4"); end
    wr('h18, 2, 1, 32'hFFFF_FFFF); rd('h18, 2, 1, "R4");
    wr('h18, 2, 1, 32'h8000_0001); rd('h18, 2, 1, "R4");
    // R5: window without auto-advance
    for (int i = 0; i < NW; i++) begin
      wr('h18, 2, 1, i); wr('h1C, 2, 1, 32'hA5A5_0000 + 32'(i * 32'h1111));
    end
    check_outs("R5");
    for (int i = 0; i < NW; i++) begin wr('h18, 2, 1, i); rd('h1C, 2, 1, "R5"); rd('h18, 2, 1, "R5"); end
    // R6: auto-advance with wrap, sub-word hold
    wr('h00, 2, 1, 32'h100); wr('h18, 2, 1, 2);
    for (int k = 0; k < 5; k++) begin
      wr('h1C, 2, 1, 32'hC0DE_0000 + 32'(k)); rd('h18, 2, 1, "R6");
    end
    check_outs("R6");
    for (int k = 0; k < 4; k++) begin rd('h1C, 2, 1, "R6"); rd('h18, 2, 1, "R6"); end
    wr('h1D, 0, 1, 32'h77); rd('h18, 2, 1, "R6");
    rd('h1E, 1, 1, "R6"); rd('h18, 2, 1, "R6");
    wr('h1C, 1, 1, 32'hBEEF); rd('h18, 2, 1, "R6"); check_outs("R6");
    // R11: sub-word merge and zero-fill, sub-word read extraction
    wr('h01, 0, 1, 32'h00); rd('h00, 2, 1, "R11");
    wr('h00, 0, 1, 32'h10); rd('h00, 2, 1, "R11");
    wr('h18, 0, 1, 32'h01); rd('h18, 2, 1, "R11");
    wr('h1E, 1, 1, 32'h1357); rd('h1C, 2, 1, "R11");
    for (int ln = 0; ln < 4; ln++) rd('h1C + ln, 0, 1, "R11");
    rd('h1C, 1, 1, "R11"); rd('h1E, 1, 1, "R11");
    wr('h29, 0, 1, 32'h01); rd('h28, 2, 1, "R11");
    wr('h28, 0, 1, 32'h01); rd('h28, 2, 1, "R11");
    wr('h35, 0, 1, 32'h01); rd('h20, 2, 1, "R11");
    rd('hFD1, 0, 1, "R11"); rd('hFE4, 1, 1, "R11");
    check_outs("R11");
    // R9: set / clear / enable
    wr('h34, 2, 1, 32'h2); rd('h20, 2, 1, "R9"); check_outs("R9");
    wr('h34, 2, 1, 32'h1); rd('h20, 2, 1, "R9"); check_outs("R9");
    rd('h34, 2, 1, "R9"); rd('h24, 2, 1, "R9");
    wr('h28, 2, 1, 32'h0); check_outs("R9");
    wr('h28, 2, 1, 32'h1); check_outs("R9");
    wr('h24, 2, 1, 32'h1); rd('h20, 2, 1, "R9"); check_outs("R9");
    // R10: fault capture and hold
    fault(32'h1000_2040, 16'hABCD, 1, 0);
    rd('h20, 2, 1, "R10"); rd('h2C, 2, 1, "R10"); rd('h30, 2, 1, "R10"); check_outs("R10");
    fault(32'h0000_3000, 16'h0012, 0, 1);
    rd('h2C, 2, 1, "R10"); rd('h30, 2, 1, "R10");
    wr('h24, 2, 1, 32'h1);
    fault(32'h0000_3000, 16'h0012, 0, 1);
    rd('h2C, 2, 1, "R10"); rd('h30, 2, 1, "R10"); check_outs("R10");
    wr('h24, 2, 1, 32'h1);
    // R7: lockdown
    wr('h00, 2, 1, 32'h8000_0110); rd('h00, 2, 1, "R7");
    wr('h00, 2, 1, 32'h0); rd('h00, 2, 1, "R7");
    wr('h01, 0, 1, 32'h0); rd('h00, 2, 1, "R7");
    wr('h18, 2, 1, 1); rd('h18, 2, 1, "R7");
    wr('h1C, 2, 1, 32'hDEAD_BEEF); rd('h18, 2, 1, "R7"); check_outs("R7");
    rd('h1C, 2, 1, "R7"); rd('h18, 2, 1, "R7");
    wr('h28, 2, 1, 32'h0); rd('h28, 2, 1, "R7");
    wr('h34, 2, 1, 32'h1); rd('h20, 2, 1, "R7"); check_outs("R7");
    wr('h24, 2, 1, 32'h1); rd('h20, 2, 1, "R7");
    // R1: reset leaves lockdown
    do_reset();
    check_outs("R1");
    for (int a = 0; a < 'h40; a += 4) rd(a, 2, 1, "R1");
    finish_run();
  end
endmodule